// File: doc/BRIEF.md
# Zero-Skip Shift Amount Calculator

This block sits beside the datapath of an iterative shift-and-add multiplier whose latency depends on the operand. Each step, the multiplier presents its current multiplier operand. The block looks at the lowest byte of that operand and reports how many bit positions the operands can advance in one step. Runs of zero bits are skipped in a single step instead of one bit at a time.

The result is the number of zero bits below the lowest set bit of the low byte. It is raised to a floor of 1 so that every step makes progress. When the low byte is entirely zero, the result is the full scan width, 8. Bits above the low byte never affect the result.

Following the FPGA-oriented house style, the result is registered. It appears one clock after the operand is presented. A synchronous active-high reset forces the result to its minimum value.

Top module: `zsk_shamt_calc`

## Requirements
- R1: The shift amount output is registered and reflects the operand sampled at the previous rising clock edge (one cycle of latency).
- R2: While the synchronous active-high reset is sampled high, the output becomes 1 at that clock edge.
- R3: When bits [7:0] of the operand are all zero, the output is 8.
- R4: When bit 0 of the operand is set, or bit 0 is clear and bit 1 is set, the output is 1.
- R5: When the lowest set bit of bits [7:0] is at position p with 2 <= p <= 7, the output equals p.
- R6: Operand bits [31:8] have no effect on the output.
- R7: Outside reset, the output always lies in the range 1 to 8 inclusive.
- R8: When several bits of the low byte are set, only the lowest set bit determines the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_in | input | 32 | Current multiplier operand |
| shamt_out | output | 4 | Registered shift amount, unsigned, 1 to 8 |

## Verification
A fault in the zero-run scan or in the floor logic shows at the ports exactly one clock after the offending operand is presented. Such a fault appears either as a shift of 0, which would stall the multiplier, or as a shift that differs from the position of the lowest set bit. A fault in the output register or the reset shows up as a stale value, or as a reset value other than 1, in that same cycle. The directed scenarios therefore check every single-bit position, the all-zero byte, mixed bit patterns and upper-bit noise, each one cycle after it is driven.

// File: rtl/zsk_pkg.sv
package zsk_pkg;

  // Default geometry of the zero-skip calculator
  localparam int unsigned ZSK_OPND_W_DEF = 32;
  localparam int unsigned ZSK_SCAN_W_DEF = 8;

  // Width needed to hold a count from 0 up to and including scan_w
  function automatic int unsigned zsk_cnt_width(input int unsigned scan_w);
    return $clog2(scan_w + 1);
  endfunction

endpackage

// File: rtl/zsk_tz_scan.sv
module zsk_tz_scan #(
  parameter int unsigned SCAN_W  = zsk_pkg::ZSK_SCAN_W_DEF,
  parameter int unsigned CNT_W   = zsk_pkg::zsk_cnt_width(SCAN_W)
) (
  input  logic [SCAN_W-1:0] bits_in,
  output logic [CNT_W-1:0]  tz_cnt,
  output logic              none_set
);

  // seen[i] is high once any bit at or below i is set
  logic [SCAN_W-1:0] seen;
  logic [SCAN_W-1:0] below_clear;

  genvar g;
  generate
    for (g = 0; g < SCAN_W; g++) begin : g_chain
      if (g == 0) begin : g_first
        assign seen[g] = bits_in[g];
      end else begin : g_rest
        assign seen[g] = seen[g-1] | bits_in[g];
      end
      assign below_clear[g] = ~seen[g];
    end
  endgenerate

  // Number of leading positions with nothing set yet is the trailing zero count
  always_comb begin
    tz_cnt = '0;
    for (int i = 0; i < SCAN_W; i++) begin
      tz_cnt = tz_cnt + CNT_W'(below_clear[i]);
    end
  end

  assign none_set = ~seen[SCAN_W-1];

endmodule

// File: rtl/zsk_floor.sv
module zsk_floor #(
  parameter int unsigned SCAN_W = zsk_pkg::ZSK_SCAN_W_DEF,
  parameter int unsigned CNT_W  = zsk_pkg::zsk_cnt_width(SCAN_W)
) (
  input  logic [CNT_W-1:0] tz_cnt,
  input  logic             none_set,
  output logic [CNT_W-1:0] shamt
);

  localparam logic [CNT_W-1:0] FULL_SKIP = CNT_W'(SCAN_W);
  localparam logic [CNT_W-1:0] MIN_STEP  = CNT_W'(1);

  always_comb begin
    if (none_set) begin
      shamt = FULL_SKIP;
    end else if (tz_cnt == '0) begin
      shamt = MIN_STEP;
    end else begin
      shamt = tz_cnt;
    end
  end

endmodule

// File: rtl/zsk_shamt_calc.sv
module zsk_shamt_calc #(
  parameter int unsigned OPND_W = zsk_pkg::ZSK_OPND_W_DEF,
  parameter int unsigned SCAN_W = zsk_pkg::ZSK_SCAN_W_DEF,
  localparam int unsigned CNT_W = zsk_pkg::zsk_cnt_width(SCAN_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPND_W-1:0] opnd_in,
  output logic [CNT_W-1:0]  shamt_out
);

  localparam logic [CNT_W-1:0] RST_STEP  = CNT_W'(1);
  localparam logic [CNT_W-1:0] FULL_SKIP = CNT_W'(SCAN_W);

  logic [SCAN_W-1:0] low_bits;
  logic [CNT_W-1:0]  tz_cnt;
  logic              none_set;
  logic [CNT_W-1:0]  shamt_nxt;

  assign low_bits = opnd_in[SCAN_W-1:0];

  generate
    if (OPND_W > SCAN_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^opnd_in[OPND_W-1:SCAN_W];
    end
  endgenerate

  zsk_tz_scan #(.SCAN_W(SCAN_W), .CNT_W(CNT_W)) u_scan (
    .bits_in  (low_bits),
    .tz_cnt   (tz_cnt),
    .none_set (none_set)
  );

  zsk_floor #(.SCAN_W(SCAN_W), .CNT_W(CNT_W)) u_floor (
    .tz_cnt   (tz_cnt),
    .none_set (none_set),
    .shamt    (shamt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      shamt_out <= RST_STEP;
    end else begin
      shamt_out <= shamt_nxt;
    end
  end

  // R7
  shamt_range_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (shamt_out != '0 && shamt_out <= FULL_SKIP));

  // R3
  zero_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (low_bits == '0) |=> (shamt_out == FULL_SKIP));

  // R4
  low_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (opnd_in[0] || opnd_in[1]) |=> (shamt_out == CNT_W'(1)));

  // R6
  hi_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(low_bits)) |=> $stable(shamt_out));

  // R2
  rst_val_chk: assert property (@(posedge clk)
    rst |=> (shamt_out == RST_STEP));

endmodule

// File: tb/tb_zsk_shamt_calc.sv
module tb_zsk_shamt_calc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd_in = '0;
  logic [3:0]  shamt_out;

  int n_chk  = 0;
  int n_pass = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  zsk_shamt_calc dut (
    .clk       (clk),
    .rst       (rst),
    .opnd_in   (opnd_in),
    .shamt_out (shamt_out)
  );

  task automatic check(input string req, input logic [3:0] exp);
    n_chk++;
    if (shamt_out === exp) n_pass++;
    else $display("FAIL %s: shamt_out=%0d expected=%0d", req, shamt_out, exp);
  endtask

  // Drive on a falling edge; result is registered at the next rising edge
  task automatic apply(input logic [31:0] v, input logic [3:0] exp, input string req);
    @(negedge clk) opnd_in = v;
    @(negedge clk) check(req, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 reset value", 4'd1);
    rst = 1'b0;
  endtask

  task automatic t_zero_byte();
    apply(32'h0000_0000, 4'd8, "R3 all zero");
    apply(32'hFFFF_FF00, 4'd8, "R3 zero low byte, upper ones");
  endtask

  task automatic t_low_bits();
    apply(32'h0000_0001, 4'd1, "R4 bit0");
    apply(32'h0000_0002, 4'd1, "R4 bit1");
    apply(32'h0000_00FF, 4'd1, "R4 all ones");
  endtask

  task automatic t_single_bits();
    for (int p = 2; p < 8; p++) begin
      apply(32'h1 << p, 4'(p), "R5 single bit");
    end
  endtask

  task automatic t_multi_bits();
    apply(32'h0000_0011, 4'd1, "R8 0x11");
    apply(32'h0000_0012, 4'd1, "R8 0x12");
    apply(32'h0000_0014, 4'd2, "R8 0x14");
    apply(32'h0000_0018, 4'd3, "R8 0x18");
    apply(32'h0000_00C0, 4'd6, "R8 0xC0");
  endtask

  task automatic t_upper_ignored();
    apply(32'hABCD_1200, 4'd8, "R6 upper noise zero byte");
    apply(32'h8000_0020, 4'd5, "R6 upper noise bit5");
    apply(32'h0000_0120, 4'd5, "R6 bit8 set");
  endtask

  task automatic t_latency();
    @(negedge clk) opnd_in = 32'h0000_0001;
    @(negedge clk) opnd_in = 32'h0000_0080;
    check("R1 first value after one cycle", 4'd1);
    @(posedge clk);
    #1 check("R1 second value after edge", 4'd7);
  endtask

  task automatic t_range_sweep();
    for (int v = 0; v < 256; v++) begin
      logic [3:0] e;
      e = 4'd8;
      for (int b = 7; b >= 0; b--) if (v[b]) e = 4'(b);
      if (e == 4'd0) e = 4'd1;
      apply(32'(v), e, "R7 sweep");
    end
  endtask

  task automatic t_mid_reset();
    apply(32'h0, 4'd8, "R3 before reset");
    @(negedge clk) rst = 1'b1;
    @(negedge clk) check("R2 reset mid run", 4'd1);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_zero_byte();
    t_low_bits();
    t_single_bits();
    t_multi_bits();
    t_upper_ignored();
    t_latency();
    t_range_sweep();
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_pass, n_chk);
      $finish;
    end
  end

endmodule